// File: doc/BRIEF.md
# Sliding-Window Parallel Rank Computer

This block computes, for every pixel of a square n x n window, how many other pixels of the same window hold a strictly smaller gray level. The window arrives as one flat vector of N = n x n eight-bit pixels, qualified by a valid strobe. The block returns N ranks in the same element order as the input, with the rank of the centre pixel also on a port of its own. A rank or median stage that follows can use the centre rank without extracting it from the vector.

The rank is not taken from a sorting network. Every ordered pair of pixels is compared at the same time, giving an N x N matrix of greater-than bits. Each row of that matrix is then counted. The comparator matrix and the per-row counters are each registered. The result therefore appears a fixed two cycles after the window, and one new window can be accepted on every clock. The window side n is an elaboration parameter. Building the window from a raster stream and any estimate made from the ranks are handled elsewhere.

Top module: `winRankEngine`

## Requirements
- R1: The rank of element i equals the number of window elements j whose pixel value is strictly below the value of element i.
- R2: Each rank field is max(1, ceil(log2(N))) bits wide and never exceeds N-1. It reaches N-1 only for a window maximum that has no equal.
- R3: Elements with equal values receive the same rank. In a window where every value is equal, all ranks are 0.
- R4: `outValid` goes high exactly two rising edges after the edge that samples `inValid` high. Windows given on consecutive cycles come out on consecutive cycles in the same order.
- R5: `outCentreRank` equals the rank of element index N/2 (integer division), which is the centre of the window in row-major order (index 4 for a 3 x 3 window), and it is valid in the same cycle as `outValid`.
- R6: A window presented with `inValid` low has no effect. While `outValid` is low, `outRanks` and `outCentreRank` keep the values of the last valid result.
- R7: After the asynchronous active-low reset, `outValid` is 0 and every rank output is 0.
- R8: Pixel i occupies bits [i*8 +: 8] of `inPixels`, and its rank occupies bits [i*RANK_W +: RANK_W] of `outRanks`. Element 0 is the top-left pixel and the order is row-major. Ranks are given in input order, not sorted order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Marks `inPixels` as a window to process |
| inPixels | input | N*PIX_W | Window pixels, element i at bits [i*PIX_W +: PIX_W], row-major |
| outValid | output | 1 | Marks the rank outputs as a fresh result |
| outRanks | output | N*RANK_W | Rank of element i at bits [i*RANK_W +: RANK_W] |
| outCentreRank | output | RANK_W | Rank of element N/2 |

## Verification
The bench targets ties, because a comparator that uses greater-or-equal gives every member of a tied group a higher rank, and a window of all-equal values then shows non-zero ranks. Fully ascending and fully descending windows with 0 and 255 at the ends catch reversed comparisons, an off-by-one in the count width, and a swapped element order. Back-to-back windows and windows sent with the valid strobe low catch a valid delay that does not match the data path, or stages that load when they should hold. The centre port is checked in every window, so the wrong centre index shows up at once.

// File: rtl/rankPkg.sv
package rankPkg;

  // Load strobes the control sends to the datapath stages
  typedef struct packed {
    logic cmpLoad;   // capture the comparison matrix
    logic sumLoad;   // capture the per-element counts
  } stageStrobes_t;

  // Width needed to hold a rank in 0 .. count-1
  function automatic int rankWidth(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/rankCtrl.sv
module rankCtrl
  import rankPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output stageStrobes_t strobes,
  output logic          outValid
);

  logic cmpValid;
  logic sumValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpValid <= 1'b0;
      sumValid <= 1'b0;
    end else begin
      cmpValid <= inValid;
      sumValid <= cmpValid;
    end
  end

  always_comb begin
    strobes.cmpLoad = inValid;
    strobes.sumLoad = cmpValid;
  end

  assign outValid = sumValid;

  // R4: an accepted window is reported exactly two edges later
  p_valid_lat_r4: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##1 outValid);

  // R4 / R6: an idle input cycle produces no result two edges later
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ##1 !outValid);

endmodule

// File: rtl/pairCompareStage.sv
module pairCompareStage #(
  parameter int NUM_EL = 9,
  parameter int PIX_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      load,
  input  logic [NUM_EL*PIX_W-1:0]   pixels,
  output logic [NUM_EL*NUM_EL-1:0]  gtBits
);

  // gtBits[i*NUM_EL + j] = pixel i strictly above pixel j
  logic [NUM_EL*NUM_EL-1:0] gtNext;

  for (genvar i = 0; i < NUM_EL; i++) begin : g_row
    for (genvar j = 0; j < NUM_EL; j++) begin : g_col
      assign gtNext[i*NUM_EL + j] =
        pixels[i*PIX_W +: PIX_W] > pixels[j*PIX_W +: PIX_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gtBits <= '0;
    end else if (load) begin
      gtBits <= gtNext;
    end
  end

  logic matrixValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matrixValid <= 1'b0;
    else       matrixValid <= load;
  end

  for (genvar i = 0; i < NUM_EL; i++) begin : g_chk
    // R1: no element counts itself as smaller
    p_self_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
      matrixValid |-> !gtBits[i*NUM_EL + i]);
    for (genvar j = i + 1; j < NUM_EL; j++) begin : g_pair
      // R3: a pair is never both above each other (ties give 0 both ways)
      p_antisym_r3: assert property (@(posedge clk) disable iff (!rstN)
        matrixValid |-> !(gtBits[i*NUM_EL + j] && gtBits[j*NUM_EL + i]));
    end
  end

endmodule

// File: rtl/rankSumStage.sv
module rankSumStage #(
  parameter int NUM_EL = 9,
  parameter int RANK_W = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      load,
  input  logic [NUM_EL*NUM_EL-1:0]  gtBits,
  output logic [NUM_EL*RANK_W-1:0]  ranks
);

  logic [NUM_EL*RANK_W-1:0] rankNext;

  for (genvar i = 0; i < NUM_EL; i++) begin : g_cnt
    always_comb begin
      logic [RANK_W-1:0] acc;
      acc = '0;
      for (int j = 0; j < NUM_EL; j++) begin
        acc = acc + RANK_W'(gtBits[i*NUM_EL + j]);
      end
      rankNext[i*RANK_W +: RANK_W] = acc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ranks <= '0;
    end else if (load) begin
      ranks <= rankNext;
    end
  end

  // R6: the result register changes only on a load
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !load |=> $stable(ranks));

  for (genvar i = 0; i < NUM_EL; i++) begin : g_bound
    // R2: a rank never exceeds N-1
    p_rank_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
      ranks[i*RANK_W +: RANK_W] <= RANK_W'(NUM_EL - 1));
  end

endmodule

// File: rtl/rankDatapath.sv
module rankDatapath
  import rankPkg::*;
#(
  parameter int NUM_EL = 9,
  parameter int PIX_W  = 8,
  parameter int RANK_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  stageStrobes_t            strobes,
  input  logic [NUM_EL*PIX_W-1:0]  pixels,
  output logic [NUM_EL*RANK_W-1:0] ranks
);

  logic [NUM_EL*NUM_EL-1:0] gtBits;

  pairCompareStage #(.NUM_EL(NUM_EL), .PIX_W(PIX_W)) u_cmp (
    .clk    (clk),
    .rstN   (rstN),
    .load   (strobes.cmpLoad),
    .pixels (pixels),
    .gtBits (gtBits)
  );

  rankSumStage #(.NUM_EL(NUM_EL), .RANK_W(RANK_W)) u_sum (
    .clk    (clk),
    .rstN   (rstN),
    .load   (strobes.sumLoad),
    .gtBits (gtBits),
    .ranks  (ranks)
  );

endmodule

// File: rtl/winRankEngine.sv
module winRankEngine
  import rankPkg::*;
#(
  parameter int WIN_SIDE = 3,
  parameter int PIX_W    = 8,
  localparam int NUM_EL  = WIN_SIDE * WIN_SIDE,
  localparam int RANK_W  = rankWidth(NUM_EL),
  localparam int CENTRE  = NUM_EL / 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [NUM_EL*PIX_W-1:0]  inPixels,
  output logic                     outValid,
  output logic [NUM_EL*RANK_W-1:0] outRanks,
  output logic [RANK_W-1:0]        outCentreRank
);

  stageStrobes_t strobes;

  rankCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  rankDatapath #(.NUM_EL(NUM_EL), .PIX_W(PIX_W), .RANK_W(RANK_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .pixels  (inPixels),
    .ranks   (outRanks)
  );

  assign outCentreRank = outRanks[CENTRE*RANK_W +: RANK_W];

endmodule

// File: tb/tb_winRankEngine.sv
`timescale 1ns/1ps
module tb_winRankEngine;

  localparam int SIDE = 3;
  localparam int PW   = 8;
  localparam int N    = SIDE * SIDE;
  localparam int RW   = 4;
  localparam int CTR  = N / 2;
  localparam real CLK_PERIOD = 20.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [N*PW-1:0] inPixels = '0;
  logic outValid;
  logic [N*RW-1:0] outRanks;
  logic [RW-1:0] outCentreRank;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  winRankEngine #(.WIN_SIDE(SIDE), .PIX_W(PW)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPixels(inPixels),
    .outValid(outValid), .outRanks(outRanks), .outCentreRank(outCentreRank)
  );

  function automatic logic [N*RW-1:0] refRanks(input logic [N*PW-1:0] w);
    logic [N*RW-1:0] r;
    for (int i = 0; i < N; i++) begin
      int c = 0;
      for (int j = 0; j < N; j++)
        if (w[j*PW +: PW] < w[i*PW +: PW]) c++;
      r[i*RW +: RW] = RW'(c);
    end
    return r;
  endfunction

  task automatic expectEq(input string req, input string what,
                          input longint act, input longint exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // compare current outputs against the reference for window w
  task automatic checkOut(input logic [N*PW-1:0] w, input string req);
    logic [N*RW-1:0] e;
    e = refRanks(w);
    expectEq("R4", {req, " valid"}, longint'(outValid), 1);
    expectEq(req, "ranks", longint'(outRanks), longint'(e));
    expectEq("R5", {req, " centre"}, longint'(outCentreRank),
             longint'(e[CTR*RW +: RW]));
  endtask

  // drive one window, idle one cycle, check at the negedge after two edges
  task automatic sendOne(input logic [N*PW-1:0] w, input string req);
    @(negedge clk); inValid = 1'b1; inPixels = w;
    @(negedge clk); inValid = 1'b0; inPixels = ~w;
    @(negedge clk); checkOut(w, req);
  endtask

  function automatic logic [N*PW-1:0] mk(input int base, input int step);
    logic [N*PW-1:0] w;
    for (int i = 0; i < N; i++) w[i*PW +: PW] = PW'(base + step * i);
    return w;
  endfunction

  task automatic tReset();
    @(negedge clk);
    // R7: reset state
    expectEq("R7", "valid after reset", longint'(outValid), 0);
    expectEq("R7", "ranks after reset", longint'(outRanks), 0);
    expectEq("R7", "centre after reset", longint'(outCentreRank), 0);
  endtask

  task automatic tOrder();
    // R8: ascending gives rank i at element i; descending the reverse
    sendOne(mk(10, 20), "R8");
    expectEq("R8", "element0 ascending", longint'(outRanks[0 +: RW]), 0);
    sendOne(mk(200, -20), "R8");
    expectEq("R8", "element0 descending", longint'(outRanks[0 +: RW]), N - 1);
  endtask

  task automatic tExtremes();
    logic [N*PW-1:0] w;
    w = mk(1, 1);
    w[0 +: PW] = 8'd255;
    w[(N-1)*PW +: PW] = 8'd0;
    // R2: unique maximum reaches N-1, unique minimum is 0
    sendOne(w, "R2");
    expectEq("R2", "max rank", longint'(outRanks[0 +: RW]), N - 1);
    expectEq("R2", "min rank", longint'(outRanks[(N-1)*RW +: RW]), 0);
  endtask

  task automatic tTies();
    logic [N*PW-1:0] w;
    // R3: all equal, all ranks zero
    sendOne({N{8'd77}}, "R3");
    expectEq("R3", "all-equal ranks", longint'(outRanks), 0);
    sendOne({N{8'd255}}, "R3");
    // R3: two value groups
    for (int i = 0; i < N; i++) w[i*PW +: PW] = (i % 2) ? 8'd9 : 8'd3;
    sendOne(w, "R3");
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < N; i++) w[i*PW +: PW] = PW'($urandom % 3);
      sendOne(w, "R3");
    end
  endtask

  task automatic tRandom();
    logic [N*PW-1:0] w;
    // R1: general random windows
    for (int k = 0; k < 20; k++) begin
      for (int i = 0; i < N; i++) w[i*PW +: PW] = PW'($urandom);
      sendOne(w, "R1");
    end
  endtask

  task automatic tStream();
    logic [N*PW-1:0] wins [8];
    // R4: back-to-back windows, results two cycles later in order
    for (int k = 0; k < 8; k++)
      for (int i = 0; i < N; i++) wins[k][i*PW +: PW] = PW'($urandom % 16);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (k >= 2) checkOut(wins[k-2], "R4");
      if (k < 8) begin inValid = 1'b1; inPixels = wins[k]; end
      else       begin inValid = 1'b0; inPixels = '0; end
    end
  endtask

  task automatic tIgnore();
    logic [N*RW-1:0] held;
    logic [N*PW-1:0] w;
    w = mk(5, 3);
    sendOne(w, "R6");
    held = outRanks;
    // R6: invalid windows leave the outputs untouched
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); inValid = 1'b0; inPixels = mk(200, -7 * (k + 1));
    end
    @(negedge clk);
    expectEq("R6", "valid stays low", longint'(outValid), 0);
    expectEq("R6", "ranks held", longint'(outRanks), longint'(held));
    expectEq("R6", "centre held", longint'(outCentreRank),
             longint'(held[CTR*RW +: RW]));
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tOrder();
    tExtremes();
    tTies();
    tRandom();
    tStream();
    tIgnore();
    repeat (2) @(negedge clk);
    finish();
  end

endmodule